// File: doc/BRIEF.md
# Mixed-Width Bit-Granular FIFO

This block is a single-clock FIFO holding 4096 bits of data, with a write port and a read port whose word widths are set apart by parameter. Each width is 1, 2, 4, 8 or 16 bits. Occupancy is kept in bits, not words, so a narrow writer can feed a wide reader or the reverse. Bits leave in the order they arrived, and the earliest stored bit lands in the least significant position of a read word.

Four registered flags report the state. FULL and EMPTY refuse an access that could not move a whole word. The two programmable flags compare the stored bit count against 12-bit thresholds, also given in bits. Two hold inputs decide what happens on an access that the flags refuse. When a hold input is high, the access is dropped. When it is low, the address counter moves on anyway: the write port overwrites, and the read port skips ahead so that the ring can be read again.

Top module: `bitfifo_mw`

## Requirements
- R1: After reset both address counters are zero, `rd_data` is zero, `empty` and `aempty` are high, and `full` and `afull` are low.
- R2: Bits are read in the order they were written, the first stored bit at `rd_data[0]`; `rd_data` changes only on the clock edge that takes a read and holds at all other times.
- R3: `empty` is high exactly when fewer than RD_W bits are stored, even if a partial word is present.
- R4: `full` is high exactly when fewer than WR_W bits are free; with a 4-bit writer and a 2-bit reader, one read from a full FIFO leaves `full` high.
- R5: `afull` is high exactly when the stored bit count is greater than or equal to `afull_lvl`.
- R6: `aempty` is high exactly when the stored bit count is less than or equal to `aempty_lvl`.
- R7: A read and a write in the same cycle are both taken, and the flags reflect the net change in stored bits.
- R8: With `hold_on_empty` high, a read while `empty` is high leaves the read address and `rd_data` unchanged.
- R9: With `hold_on_empty` low, a read while `empty` is high advances the read address by RD_W bits and leaves the stored count unchanged.
- R10: With `hold_on_full` high, a write while `full` is high changes neither the stored data nor the write address.
- R11: With `hold_on_full` low, a write while `full` is high stores its word at the write address, advances that address by WR_W bits and leaves the stored count unchanged.
- R12: All four flags are registers and change on the same clock edge that takes the access that moves the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Read word, registered |
| afull_lvl | input | 12 | Almost-full threshold in bits |
| aempty_lvl | input | 12 | Almost-empty threshold in bits |
| hold_on_empty | input | 1 | Freeze the read address while empty |
| hold_on_full | input | 1 | Freeze the write address while full |
| full | output | 1 | Fewer than WR_W bits free |
| empty | output | 1 | Fewer than RD_W bits stored |
| afull | output | 1 | Stored bits at or above the almost-full threshold |
| aempty | output | 1 | Stored bits at or below the almost-empty threshold |

## Verification
On every cycle the assertions check the address counter steps: frozen under either hold input, a full step when a refused access goes through anyway, and a still read address and read word when no read is requested. They also check that `full` and `empty` never appear together and that `full` only rises after a write. Only the bench scenarios can show the bit ordering across the width change and the exact flag thresholds at the word that crosses them. The same holds for the overwrite landing on the oldest data, and for the read that follows a skip coming from RD_W bits further on.

// File: rtl/bitfifo_pkg.sv
`timescale 1ns/1ps
package bitfifo_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned CAP_BITS = 1 << ADDR_W;
  localparam int unsigned CNT_W    = ADDR_W + 1;

  function automatic int unsigned min_w(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/bitfifo_ptr.sv
`timescale 1ns/1ps
module bitfifo_ptr #(
  parameter int unsigned STEP = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            adv,
  output logic [bitfifo_pkg::ADDR_W-1:0]  addr
);
  import bitfifo_pkg::*;
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)      addr <= '0;
    else if (adv) addr <= addr + INC;
  end
endmodule

// File: rtl/bitfifo_store.sv
`timescale 1ns/1ps
module bitfifo_store #(
  parameter int unsigned WR_W = 4,
  parameter int unsigned RD_W = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [bitfifo_pkg::ADDR_W-1:0]  waddr,
  input  logic [WR_W-1:0]                 wdata,
  input  logic                            re,
  input  logic [bitfifo_pkg::ADDR_W-1:0]  raddr,
  output logic [RD_W-1:0]                 rdata
);
  import bitfifo_pkg::*;
  localparam int unsigned GRAN   = min_w(WR_W, RD_W);
  localparam int unsigned GSH    = $clog2(GRAN);
  localparam int unsigned ROW_W  = ADDR_W - GSH;
  localparam int unsigned DEPTH  = CAP_BITS / GRAN;
  localparam int unsigned WLANES = WR_W / GRAN;
  localparam int unsigned RLANES = RD_W / GRAN;

  logic [GRAN-1:0]  mem [DEPTH];
  logic [ROW_W-1:0] wrow, rrow;
  logic [RD_W-1:0]  rword;

  assign wrow = waddr[ADDR_W-1:GSH];
  assign rrow = raddr[ADDR_W-1:GSH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < WLANES; k++) begin
        mem[wrow + ROW_W'(k)] <= wdata[k*GRAN +: GRAN];
      end
    end
  end

  for (genvar g = 0; g < RLANES; g++) begin : g_rlane
    assign rword[g*GRAN +: GRAN] = mem[rrow + ROW_W'(g)];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rword;
  end
endmodule

// File: rtl/bitfifo_flags.sv
`timescale 1ns/1ps
module bitfifo_flags #(
  parameter int unsigned WR_W = 4,
  parameter int unsigned RD_W = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_take,
  input  logic                            rd_take,
  input  logic [bitfifo_pkg::ADDR_W-1:0]  afull_lvl,
  input  logic [bitfifo_pkg::ADDR_W-1:0]  aempty_lvl,
  output logic                            full,
  output logic                            empty,
  output logic                            afull,
  output logic                            aempty
);
  import bitfifo_pkg::*;
  localparam logic [CNT_W-1:0] WSTEP   = CNT_W'(WR_W);
  localparam logic [CNT_W-1:0] RSTEP   = CNT_W'(RD_W);
  localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(CAP_BITS - WR_W);

  logic [CNT_W-1:0] fill_q, fill_n;

  always_comb begin
    fill_n = fill_q;
    if (wr_take) fill_n = fill_n + WSTEP;
    if (rd_take) fill_n = fill_n - RSTEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
      afull  <= 1'b0;
      aempty <= 1'b1;
    end else begin
      fill_q <= fill_n;
      full   <= fill_n > FULL_AT;
      empty  <= fill_n < RSTEP;
      afull  <= fill_n >= {1'b0, afull_lvl};
      aempty <= fill_n <= {1'b0, aempty_lvl};
    end
  end
endmodule

// File: rtl/bitfifo_mw.sv
`timescale 1ns/1ps
module bitfifo_mw #(
  parameter int unsigned WR_W = 4,
  parameter int unsigned RD_W = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [WR_W-1:0]                 wr_data,
  input  logic                            rd_en,
  output logic [RD_W-1:0]                 rd_data,
  input  logic [bitfifo_pkg::ADDR_W-1:0]  afull_lvl,
  input  logic [bitfifo_pkg::ADDR_W-1:0]  aempty_lvl,
  input  logic                            hold_on_empty,
  input  logic                            hold_on_full,
  output logic                            full,
  output logic                            empty,
  output logic                            afull,
  output logic                            aempty
);
  import bitfifo_pkg::*;

  logic              wr_take, rd_take, wr_move, rd_move;
  logic [ADDR_W-1:0] waddr, raddr;

  // a take changes the count; a move only steps the address
  assign wr_take = wr_en && !full;
  assign rd_take = rd_en && !empty;
  assign wr_move = wr_en && (!full  || !hold_on_full);
  assign rd_move = rd_en && (!empty || !hold_on_empty);

  bitfifo_ptr #(.STEP(WR_W)) u_wptr (
    .clk(clk), .rst(rst), .adv(wr_move), .addr(waddr)
  );

  bitfifo_ptr #(.STEP(RD_W)) u_rptr (
    .clk(clk), .rst(rst), .adv(rd_move), .addr(raddr)
  );

  bitfifo_store #(.WR_W(WR_W), .RD_W(RD_W)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_move), .waddr(waddr), .wdata(wr_data),
    .re(rd_move), .raddr(raddr), .rdata(rd_data)
  );

  bitfifo_flags #(.WR_W(WR_W), .RD_W(RD_W)) u_flags (
    .clk(clk), .rst(rst),
    .wr_take(wr_take), .rd_take(rd_take),
    .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
    .full(full), .empty(empty), .afull(afull), .aempty(aempty)
  );
endmodule

// File: rtl/bitfifo_mw_chk.sv
`timescale 1ns/1ps
module bitfifo_mw_chk #(
  parameter int unsigned WR_W = 4,
  parameter int unsigned RD_W = 2
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            wr_en,
  input logic                            rd_en,
  input logic                            hold_on_empty,
  input logic                            hold_on_full,
  input logic                            full,
  input logic                            empty,
  input logic [bitfifo_pkg::ADDR_W-1:0]  waddr,
  input logic [bitfifo_pkg::ADDR_W-1:0]  raddr,
  input logic [RD_W-1:0]                 rd_data
);
  import bitfifo_pkg::*;

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_full_after_write_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(wr_en));

  assert_rd_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    hold_on_empty && empty && rd_en |=> $stable(raddr) && $stable(rd_data));

  assert_rd_skip_R9: assert property (@(posedge clk) disable iff (rst)
    !hold_on_empty && empty && rd_en |=> raddr == $past(raddr) + ADDR_W'(RD_W));

  assert_wr_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    hold_on_full && full && wr_en |=> $stable(waddr));

  assert_wr_step_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en && (!full || !hold_on_full) |=> waddr == $past(waddr) + ADDR_W'(WR_W));

  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data) && $stable(raddr));
endmodule

bind bitfifo_mw bitfifo_mw_chk #(.WR_W(WR_W), .RD_W(RD_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .hold_on_empty(hold_on_empty), .hold_on_full(hold_on_full),
  .full(full), .empty(empty), .waddr(waddr), .raddr(raddr),
  .rd_data(rd_data)
);

// File: tb/bitfifo_mw_tb_top.sv
`timescale 1ns/1ps
module bitfifo_mw_tb_top;
  localparam int WR_W = 4;
  localparam int RD_W = 2;
  localparam int CAP  = 4096;
  localparam int AF   = 4000;
  localparam int AE   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [WR_W-1:0] wr_data = '0;
  logic [RD_W-1:0] rd_data;
  logic [11:0]     afull_lvl = 12'(AF), aempty_lvl = 12'(AE);
  logic            hold_on_empty = 1'b1, hold_on_full = 1'b1;
  logic            full, empty, afull, aempty;

  int n_chk = 0, n_bad = 0;
  bit mq[$];
  logic [RD_W-1:0] exp_q[$];
  logic exp_now = 1'b0, pend = 1'b0;

  always #2 clk = ~clk;

  bitfifo_mw #(.WR_W(WR_W), .RD_W(RD_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .afull_lvl(afull_lvl),
    .aempty_lvl(aempty_lvl), .hold_on_empty(hold_on_empty),
    .hold_on_full(hold_on_full), .full(full), .empty(empty),
    .afull(afull), .aempty(aempty)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares each scoreboard item on the negedge after its read edge
  always @(posedge clk) pend <= exp_now && !rst;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("R2 queue", 16'd1, 16'd0);
      else check("R2 read data", 16'(rd_data), 16'(exp_q.pop_front()));
    end
  end

  task automatic check_flags();
    check("R3 empty",  16'(empty),  16'(mq.size() < RD_W));
    check("R4 full",   16'(full),   16'((CAP - mq.size()) < WR_W));
    check("R5 afull",  16'(afull),  16'(mq.size() >= AF));
    check("R6 aempty", 16'(aempty), 16'(mq.size() <= AE));
  endtask

  // driver: inputs change at a negedge, flags checked at the next negedge
  task automatic step(bit w, logic [WR_W-1:0] d, bit r);
    bit mfull  = (CAP - mq.size()) < WR_W;
    bit mempty = mq.size() < RD_W;
    wr_en = w; wr_data = d; rd_en = r; exp_now = 1'b0;
    if (r && !mempty) begin
      logic [RD_W-1:0] e;
      for (int k = 0; k < RD_W; k++) e[k] = mq.pop_front();
      exp_q.push_back(e);
      exp_now = 1'b1;
    end
    if (w) begin
      if (!mfull) for (int k = 0; k < WR_W; k++) mq.push_back(d[k]);
      else if (!hold_on_full) for (int k = 0; k < WR_W; k++) mq[k] = d[k];
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; exp_now = 1'b0;
    check_flags();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    mq.delete(); exp_q.delete();
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [RD_W-1:0] held;
    do_reset();
    // R1 reset state
    check("R1 empty",   16'(empty),   16'd1);
    check("R1 aempty",  16'(aempty),  16'd1);
    check("R1 full",    16'(full),    16'd0);
    check("R1 afull",   16'(afull),   16'd0);
    check("R1 rd_data", 16'(rd_data), 16'd0);

    // R2 ordering, R6 threshold crossing with writes and reads
    step(1, 4'b0110, 0);
    step(1, 4'b1001, 0);
    step(1, 4'b0011, 0);          // 12 bits: aempty falls (R6)
    step(0, '0, 1);
    step(0, '0, 1);               // 8 bits: aempty rises (R6, R12)
    step(1, 4'b1110, 1);          // R7 simultaneous: net +2
    check("R7 aempty after net +2", 16'(aempty), 16'd0);
    for (int i = 0; i < 5; i++) step(0, '0, 1);
    check("R3 drained", 16'(empty), 16'd1);

    // R8: hold read while empty
    held = rd_data;
    step(0, '0, 1);
    check("R8 rd_data held", 16'(rd_data), 16'(held));
    step(1, 4'b1011, 0);
    step(0, '0, 1);               // scoreboard expects 2'b11 (R8 no skip)

    // R9: skip on empty with hold low
    do_reset();
    hold_on_empty = 1'b0;
    step(0, '0, 1);               // read pointer moves to bit 2
    hold_on_empty = 1'b1;
    wr_en = 1'b1; wr_data = 4'b0110;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 read after skip", 16'(rd_data), 16'b01);
    check("R9 count kept", 16'(empty), 16'd0);

    // R4, R5, R10, R11: fill to the brim
    do_reset();
    for (int i = 0; i < CAP / WR_W; i++) step(1, 4'(i) ^ 4'h9, 0);
    check("R4 full at capacity", 16'(full), 16'd1);
    check("R5 afull at capacity", 16'(afull), 16'd1);
    step(1, 4'hF, 0);             // R10 ignored
    hold_on_full = 1'b0;
    step(1, 4'h5, 0);             // R11 overwrites oldest word
    hold_on_full = 1'b1;
    step(0, '0, 1);
    check("R4 full after one narrow read", 16'(full), 16'd1);
    step(0, '0, 1);
    check("R4 full clears", 16'(full), 16'd0);
    for (int i = 0; i < CAP / RD_W - 2; i++) step(0, '0, 1);
    check("R10 R11 all drained", 16'(empty), 16'd1);
    @(negedge clk);
    check("R2 scoreboard empty", 16'(exp_q.size()), 16'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule